// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Engine

This block is one DMA channel that copies data units from a source address to a destination address. Each unit moves as a read followed by a write, and the two bus cycles always stay together. Software sets up the channel through a small register port. It loads the start addresses, an address-stepping rule for each side, a transfer count, a block size and a transfer mode, then sets the enable bit. The engine asks for the bus with a request/grant handshake and runs read/write pairs. It gives the bus back according to the mode: after every pair in cycle-steal mode, once at the end in burst mode, and after every block in block mode.

A transfer can be stopped at any time with the abort input, or by writing 0 to the enable bit. The pair in flight still completes, and then the channel stops with all its registers intact. The address registers already point at the next unit. If the stop fell inside a block, a block-error flag records it. Setting the enable bit again with that flag kept at 1 continues from the same position inside the block. Reset and the standby input both clear the channel at once.

Top module: `dma_chan_engine`

## Requirements
- R1: Reset or standby clears every register to 0, drops the bus request and any pair in flight, and leaves no read or write strobe active in the following cycle.
- R2: Each pair reads the source address and then writes the data read to the destination address. A write always follows a read that has been acknowledged, even when an abort arrives during the pair, and the read and write strobes are never active together.
- R3: Each address moves by one after every pair, following its 2-bit mode field: 01 increments, 10 decrements, 00 and 11 hold the address fixed. The source field is control bits [6:5] and the destination field is bits [8:7].
- R4: In cycle-steal mode (control bits [4:3] = 00), the count drops by one per pair and the bus request falls for at least one cycle after every pair. The request rises in the cycle after the enable write.
- R5: In burst mode (bits [4:3] = 01), the count drops by one per pair and the request stays high from the first pair to the last. Strobes appear only while the request is high.
- R6: In block mode (bits [4:3] = 10), the block-remaining counter (register 5) drops by one per pair. It reloads from the block size (register 4) when a block ends, and at that point the count (register 3) drops by one and the bus is released.
- R7: When the count reaches 0, the done flag (control bit 2) sets and the enable bit (control bit 0) clears in the same cycle.
- R8: An abort, either as an input pulse or as a control write with bit 0 = 0 while enabled, lets the current pair finish and then clears the enable bit. The count, block-remaining counter and source/destination registers (1 and 2) keep their values and already point at the next unit.
- R9: An abort in block mode that leaves the block-remaining counter different from the block size sets the block-error flag (control bit 1). An abort at a block boundary leaves the flag at 0.
- R10: Setting the enable bit with control bit 1 written as 1 while the block-error flag is set keeps the block-remaining counter and resumes inside the block. Any other enable reloads the counter from the block size.
- R11: A control write with bit 1 = 0 clears the block-error flag, and writing 1 never sets it. The flag also clears when a block completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Synchronous clear, same effect as reset |
| abort | input | 1 | Stop request, honoured at the end of the current pair |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 control, 1 source, 2 destination, 3 count, 4 block size, 5 block remaining (read only) |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data for cfg_addr, combinational |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Address of the current read or write |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack during a read |
| bus_ack | input | 1 | Cycle acknowledge that ends the current strobe |

## Verification
A register write lands on the clock edge inside the write task, so its effect is sampled at the next falling edge. The bus request therefore shows high one falling edge after the enable write. A pair takes four cycles with the one-cycle-acknowledge memory, and the enable, done, block-error and count results all change on the edge that accepts the final write acknowledge. The bench polls the control register on falling edges and compares only once enable has dropped. Aborts and standby are driven on the falling edge where a watched bus event is first seen, so the stop lands in a known cycle: during a read, mid-block, or in the release gap at a block boundary. The expected register values then follow directly from the pair count.

// File: rtl/dmace_pkg.sv
package dmace_pkg;

    typedef enum logic [1:0] {
        XM_STEAL = 2'd0,
        XM_BURST = 2'd1,
        XM_BLOCK = 2'd2,
        XM_RSVD  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_GAP  = 2'd3
    } eng_state_e;

    // Control word: bit0 enable, bit1 block error, bit2 done,
    // [4:3] transfer mode, [6:5] source step, [8:7] destination step
    typedef struct packed {
        addr_mode_e dmode;
        addr_mode_e smode;
        xfer_mode_e xmode;
        logic       done;
        logic       berr;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_SRC  = 3'd1;
    localparam logic [2:0] RA_DST  = 3'd2;
    localparam logic [2:0] RA_CNT  = 3'd3;
    localparam logic [2:0] RA_BSZ  = 3'd4;
    localparam logic [2:0] RA_BREM = 3'd5;

    // Two's complement step of one unit
    function automatic logic [1:0] step_delta(addr_mode_e m);
        case (m)
            AM_INC:  return 2'b01;
            AM_DEC:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/dmace_addr_unit.sv
module dmace_addr_unit
    import dmace_pkg::*;
#(
    parameter int AW    = 16,
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0][AW-1:0] cur,
    input  logic [NPORT-1:0][1:0]    mode,
    output logic [NPORT-1:0][AW-1:0] nxt
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic [1:0] d;
        assign d      = step_delta(addr_mode_e'(mode[g]));
        assign nxt[g] = cur[g] + {{(AW-2){d[1]}}, d};
    end
endmodule

// File: rtl/dmace_fsm.sv
module dmace_fsm
    import dmace_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          keep,
    input  logic          bus_gnt,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          pair_done
);
    eng_state_e st;

    always_comb begin
        bus_rd    = (st == ST_RD);
        bus_wr    = (st == ST_WR);
        busy      = bus_rd || bus_wr;
        bus_req   = (st == ST_IDLE) ? go : busy;
        pair_done = bus_wr && bus_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bus_wdata <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go && bus_gnt) st <= ST_RD;
                ST_RD: begin
                    if (bus_ack) begin
                        bus_wdata <= bus_rdata;
                        st        <= ST_WR;
                    end
                end
                ST_WR: if (bus_ack) st <= keep ? ST_RD : ST_GAP;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmace_regs.sv
module dmace_regs
    import dmace_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          abort,
    input  logic          busy,
    input  logic          pair_done,
    input  logic [AW-1:0] src_nxt,
    input  logic [AW-1:0] dst_nxt,
    output ctrl_t         ctrl,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] count,
    output logic [BW-1:0] bsize,
    output logic [BW-1:0] brem,
    output logic          go,
    output logic          keep
);
    logic          pend;
    logic          ctrl_wr, abort_req, blk, last_in_blk, cnt_dec;
    logic [CW-1:0] cnt_after;
    logic [BW-1:0] brem_after;

    always_comb begin
        ctrl_wr     = cfg_we && (cfg_addr == RA_CTRL);
        abort_req   = abort || (ctrl_wr && !cfg_wdata[0] && ctrl.en);
        blk         = (ctrl.xmode == XM_BLOCK);
        last_in_blk = blk && (brem <= BW'(1));
        cnt_dec     = !blk || last_in_blk;
        cnt_after   = count - CW'(cnt_dec);
        brem_after  = !blk ? brem : (last_in_blk ? bsize : brem - BW'(1));
        go          = ctrl.en && (count != '0) && !abort_req && !pend;
        keep        = !abort_req && !pend &&
                      (((ctrl.xmode == XM_BURST) && (count > CW'(1))) ||
                       (blk && (brem > BW'(1))));
    end

    always_comb begin
        case (cfg_addr)
            RA_CTRL: cfg_rdata = AW'(ctrl);
            RA_SRC:  cfg_rdata = src;
            RA_DST:  cfg_rdata = dst;
            RA_CNT:  cfg_rdata = AW'(count);
            RA_BSZ:  cfg_rdata = AW'(bsize);
            RA_BREM: cfg_rdata = AW'(brem);
            default: cfg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            src   <= '0;
            dst   <= '0;
            count <= '0;
            bsize <= '0;
            brem  <= '0;
            pend  <= 1'b0;
        end else begin
            if (abort_req && ctrl.en && busy) pend <= 1'b1;

            if (cfg_we) begin
                case (cfg_addr)
                    RA_CTRL: begin
                        ctrl.xmode <= xfer_mode_e'(cfg_wdata[4:3]);
                        ctrl.smode <= addr_mode_e'(cfg_wdata[6:5]);
                        ctrl.dmode <= addr_mode_e'(cfg_wdata[8:7]);
                        if (!cfg_wdata[1]) ctrl.berr <= 1'b0;
                        if (!cfg_wdata[2]) ctrl.done <= 1'b0;
                        if (cfg_wdata[0] && !ctrl.en) begin
                            ctrl.en   <= 1'b1;
                            ctrl.done <= 1'b0;
                            pend      <= 1'b0;
                            if (!(cfg_wdata[1] && ctrl.berr)) brem <= bsize;
                        end
                    end
                    RA_SRC: src   <= cfg_wdata;
                    RA_DST: dst   <= cfg_wdata;
                    RA_CNT: count <= cfg_wdata[CW-1:0];
                    RA_BSZ: bsize <= cfg_wdata[BW-1:0];
                    default: ;
                endcase
            end

            if (pair_done) begin
                src   <= src_nxt;
                dst   <= dst_nxt;
                count <= cnt_after;
                brem  <= brem_after;
                if (last_in_blk) ctrl.berr <= 1'b0;
                if (cnt_after == '0) begin
                    ctrl.done <= 1'b1;
                    ctrl.en   <= 1'b0;
                    pend      <= 1'b0;
                end else if (pend || abort_req) begin
                    ctrl.en <= 1'b0;
                    pend    <= 1'b0;
                    if (blk && (brem_after != bsize)) ctrl.berr <= 1'b1;
                end
            end else if (abort_req && ctrl.en && !busy) begin
                ctrl.en <= 1'b0;
                if (blk && (brem != bsize)) ctrl.berr <= 1'b1;
            end else if (ctrl.en && !busy && (count == '0)) begin
                ctrl.done <= 1'b1;
                ctrl.en   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dmace_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          standby,
    input  logic          abort,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);
    localparam int NPORT = 2;

    logic                    clr;
    ctrl_t                   ctrl_q;
    logic [AW-1:0]           src_q, dst_q;
    logic [CW-1:0]           count_q;
    logic [BW-1:0]           bsize_q, brem_q;
    logic                    go, keep, busy, pair_done;
    logic [NPORT-1:0][AW-1:0] a_cur, a_nxt;
    logic [NPORT-1:0][1:0]    a_mode;
    logic                    chan_en, chan_done;
    xfer_mode_e              chan_mode;

    assign clr       = rst || standby;
    assign a_cur     = {dst_q, src_q};
    assign a_mode    = {ctrl_q.dmode, ctrl_q.smode};
    assign bus_addr  = bus_wr ? dst_q : src_q;
    assign chan_en   = ctrl_q.en;
    assign chan_done = ctrl_q.done;
    assign chan_mode = ctrl_q.xmode;

    dmace_regs #(.AW(AW), .CW(CW), .BW(BW)) u_regs (
        .clk       (clk),
        .rst       (clr),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .abort     (abort),
        .busy      (busy),
        .pair_done (pair_done),
        .src_nxt   (a_nxt[0]),
        .dst_nxt   (a_nxt[1]),
        .ctrl      (ctrl_q),
        .src       (src_q),
        .dst       (dst_q),
        .count     (count_q),
        .bsize     (bsize_q),
        .brem      (brem_q),
        .go        (go),
        .keep      (keep)
    );

    dmace_addr_unit #(.AW(AW), .NPORT(NPORT)) u_addr (
        .cur  (a_cur),
        .mode (a_mode),
        .nxt  (a_nxt)
    );

    dmace_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (clr),
        .go        (go),
        .keep      (keep),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .pair_done (pair_done)
    );
endmodule

// File: rtl/dmace_chk.sv
module dmace_chk
    import dmace_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_ack,
    input logic       chan_en,
    input logic       chan_done,
    input xfer_mode_e chan_mode
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!bus_req && !bus_rd && !bus_wr)); // R1
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr)); // R2
    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_ack) |=> bus_wr); // R2
    AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (rst) (bus_rd || bus_wr) |-> bus_req); // R5
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ((chan_mode != XM_BURST) && (chan_mode != XM_BLOCK) && bus_wr && bus_ack) |=> !bus_req); // R4
    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (rst) $rose(chan_done) |-> !chan_en); // R7
endmodule

bind dma_chan_engine dmace_chk u_chk (
    .clk       (clk),
    .rst       (clr),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ack   (bus_ack),
    .chan_en   (chan_en),
    .chan_done (chan_done),
    .chan_mode (chan_mode)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          standby = 1'b0;
    logic          abort = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = 3'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          bus_req, bus_rd, bus_wr;
    logic          bus_gnt = 1'b1;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ack;

    int errors = 0;
    int checks = 0;
    int wr_acks = 0;
    int req_falls = 0;
    logic prev_req;
    logic fill_go = 1'b0;
    int   fill_seed = 0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] exp_mem [256];
    logic [AW-1:0] m_src, m_dst;

    always #2 clk = ~clk;

    dma_chan_engine u_dut (
        .clk(clk), .rst(rst), .standby(standby), .abort(abort),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [DW-1:0] pat(int i, int s);
        return DW'(i * 37 + s * 101 + 5);
    endfunction

    function automatic logic [AW-1:0] bstep(logic [AW-1:0] a, int m);
        if (m == 1) return a + 1'b1;
        if (m == 2) return a - 1'b1;
        return a;
    endfunction

    // memory with one-cycle acknowledge
    always @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= (bus_rd || bus_wr) && !bus_ack;
            bus_rdata <= mem[bus_addr[7:0]];
        end
        if (fill_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
        end else if (bus_wr && bus_ack) begin
            mem[bus_addr[7:0]] <= bus_wdata;
        end
    end

    always @(posedge clk) begin
        prev_req <= bus_req;
        if (bus_wr && bus_ack) wr_acks <= wr_acks + 1;
        if (prev_req && !bus_req) req_falls <= req_falls + 1;
    end

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [AW-1:0] v);
        cfg_addr = a;
        #0.5;
        v = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [AW-1:0] v;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cfg_read(3'd0, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int s);
        @(negedge clk);
        fill_seed = s; fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
        for (int i = 0; i < 256; i++) exp_mem[i] = pat(i, s);
    endtask

    task automatic model(input logic [AW-1:0] s0, input logic [AW-1:0] d0, input int sm, input int dm, input int pairs);
        m_src = s0; m_dst = d0;
        for (int p = 0; p < pairs; p++) begin
            exp_mem[m_dst[7:0]] = exp_mem[m_src[7:0]];
            m_src = bstep(m_src, sm);
            m_dst = bstep(m_dst, dm);
        end
    endtask

    function automatic logic [AW-1:0] ctrl_word(int xm, int sm, int dm, bit berr, bit en);
        return AW'({dm[1:0], sm[1:0], xm[1:0], 1'b0, berr, en});
    endfunction

    task automatic check_mem(input string r);
        int mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk(r, "memory mismatches", mism, 0);
    endtask

    task automatic setup(input logic [AW-1:0] s0, input logic [AW-1:0] d0, input int cnt, input int bsz);
        cfg_write(3'd1, s0);
        cfg_write(3'd2, d0);
        cfg_write(3'd3, AW'(cnt));
        cfg_write(3'd4, AW'(bsz));
    endtask

    task automatic run_xfer(input int xm, input int sm, input int dm,
                            input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                            input int cnt, input int bsz, input int seed);
        logic [AW-1:0] v;
        int f0, w0, pairs;
        fill(seed);
        setup(s0, d0, cnt, bsz);
        f0 = req_falls; w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(xm, sm, dm, 1'b0, 1'b1));
        wait_idle();
        pairs = (xm == 2) ? cnt * bsz : cnt;
        model(s0, d0, sm, dm, pairs);
        check_mem("R2");
        chk("R2", "write count", wr_acks - w0, pairs);
        cfg_read(3'd0, v);
        chk("R7", "enable bit", v[0], 0);
        chk("R7", "done bit", v[2], 1);
        cfg_read(3'd3, v); chk("R7", "count", v, 0);
        cfg_read(3'd1, v); chk("R3", "source address", v, m_src);
        cfg_read(3'd2, v); chk("R3", "destination address", v, m_dst);
        if (xm == 0) chk("R4", "steal releases", req_falls - f0, cnt);
        else if (xm == 1) chk("R5", "burst releases", req_falls - f0, 1);
        else begin
            chk("R6", "block releases", req_falls - f0, cnt);
            cfg_read(3'd5, v); chk("R6", "block remaining reload", v, bsz);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] v;
        int w0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        for (int a = 0; a < 6; a++) begin
            cfg_read(3'(a), v);
            chk("R1", "register after reset", v, 0);
        end
        chk("R1", "bus request after reset", bus_req, 0);

        // directed mode coverage
        run_xfer(0, 1, 1, 16'd10, 16'd100, 4, 1, 1);
        run_xfer(1, 2, 1, 16'd50, 16'd150, 5, 1, 2);
        run_xfer(2, 1, 2, 16'd20, 16'd220, 3, 3, 3);
        run_xfer(1, 0, 3, 16'd7, 16'd77, 3, 1, 4);

        // random
        for (int r = 0; r < 12; r++) begin
            run_xfer($urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 3),
                     AW'($urandom_range(0, 255)), AW'($urandom_range(0, 255)),
                     $urandom_range(1, 6), $urandom_range(1, 4), 10 + r);
        end

        // abort mid-block, then resume inside the block
        fill(40);
        setup(16'd10, 16'd200, 2, 4);
        w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b0, 1'b1));
        while (wr_acks - w0 < 1) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        chk("R2", "pair in flight completed", wr_acks - w0, 2);
        cfg_read(3'd0, v);
        chk("R8", "enable after abort", v[0], 0);
        chk("R9", "block error after mid-block abort", v[1], 1);
        cfg_read(3'd5, v); chk("R8", "block remaining kept", v, 2);
        cfg_read(3'd3, v); chk("R8", "count kept", v, 2);
        cfg_read(3'd1, v); chk("R8", "source points at next", v, 12);
        cfg_read(3'd2, v); chk("R8", "destination points at next", v, 202);
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b1, 1'b1));
        wait_idle();
        model(16'd10, 16'd200, 1, 1, 8);
        check_mem("R10");
        chk("R10", "total writes after resume", wr_acks - w0, 8);
        cfg_read(3'd0, v);
        chk("R11", "block error cleared by normal block end", v[1], 0);
        chk("R7", "done after resume", v[2], 1);

        // abort mid-block, clear flag, enable reloads block counter
        setup(16'd30, 16'd130, 3, 4);
        w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b0, 1'b1));
        while (wr_acks - w0 < 1) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        cfg_read(3'd0, v); chk("R9", "block error set", v[1], 1);
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b0, 1'b0));
        cfg_read(3'd0, v); chk("R11", "block error cleared by write 0", v[1], 0);
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b1, 1'b0));
        cfg_read(3'd0, v); chk("R11", "write 1 does not set block error", v[1], 0);
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b0, 1'b1));
        cfg_read(3'd5, v); chk("R10", "fresh enable reloads block counter", v, 4);
        wait_idle();
        chk("R10", "writes with restarted block", wr_acks - w0, 14);

        // abort at a block boundary
        setup(16'd60, 16'd160, 2, 2);
        w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(2, 1, 1, 1'b0, 1'b1));
        while (wr_acks - w0 < 2) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        cfg_read(3'd0, v);
        chk("R9", "no block error at boundary", v[1], 0);
        chk("R8", "enable after boundary abort", v[0], 0);
        cfg_read(3'd3, v); chk("R6", "count after one block", v, 1);
        chk("R8", "no further pair", wr_acks - w0, 2);

        // abort during a read in cycle-steal mode
        setup(16'd5, 16'd105, 3, 1);
        w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(0, 1, 1, 1'b0, 1'b1));
        chk("R4", "request in cycle after enable", bus_req, 1);
        while (!bus_rd) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle();
        chk("R2", "write follows aborted read", wr_acks - w0, 1);
        cfg_read(3'd3, v); chk("R8", "count after read abort", v, 2);
        cfg_read(3'd0, v); chk("R8", "enable after read abort", v[0], 0);

        // standby mid-burst
        setup(16'd1, 16'd201, 20, 1);
        w0 = wr_acks;
        cfg_write(3'd0, ctrl_word(1, 1, 1, 1'b0, 1'b1));
        while (wr_acks - w0 < 3) @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        chk("R1", "request after standby", bus_req, 0);
        chk("R1", "strobes after standby", bus_rd | bus_wr, 0);
        for (int a = 0; a < 6; a++) begin
            cfg_read(3'(a), v);
            chk("R1", "register after standby", v, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule